// File: doc/BRIEF.md
# Multichannel Binary-Code Correlator

This block correlates a time-multiplexed stream of samples against stored binary code sequences, one per channel. Each sample arrives with a channel index and a block-start flag through a valid/ready handshake. The block shifts the sample into that channel's tap history and then adds up the taps over several cycles. Each tap is added or subtracted according to one code bit. The result leaves on a one-cycle strobe, together with the channel index and the block-start flag of the sample that started it.

The taps used are the newest sample and then every OSR-th older sample, so a channel keeps (N-1)*OSR+1 samples. CELLS taps are summed in each cycle, so one correlation takes ceil(N/CELLS) cycles. Only one correlation runs at a time. The ready output stays low while it runs, which is what keeps the tap history of the channel being processed from being overwritten. The code sequences are written one channel at a time through a plain write port. A parameter chooses whether samples are read as signed or unsigned.

Top module: `bincorr_top`

## Requirements
- R1: While rst_ni is low and right after it rises, in_ready_o is 1 and out_valid_o is 0. Every tap history and every code sequence is all zeros, so each code bit weighs its tap by -1.
- R2: A result equals the sum over k=0..N-1 of s_k*x_k. x_k is the sample accepted k*OSR acceptances earlier on the same channel, x_0 is the sample that started the correlation, and a sample never written counts as 0. s_k is +1 when code bit k is 1 and -1 when it is 0.
- R3: With IN_SIGNED=1 samples are read as two's complement; with IN_SIGNED=0 they are read as unsigned. out_data_o is a two's complement value of DATA_W+clog2(N)+1 bits.
- R4: A sample enters only the history of the channel given on in_chan_i. Other channels' histories are unchanged.
- R5: out_chan_o and out_bs_o show the channel and the block-start flag of the sample that started the result while out_valid_o is 1.
- R6: A sample is accepted on a rising edge with in_valid_i=1 and in_ready_o=1. in_ready_o is then 0 until the result appears, and returns to 1 in the same cycle as out_valid_o. in_valid_i is ignored while in_ready_o is 0.
- R7: out_valid_o rises STEPS=ceil(N/CELLS) rising edges after the accepting edge and lasts exactly one cycle.
- R8: coef_we_i=1 on a rising edge stores coef_data_i as the code sequence of channel coef_addr_i, with bit k paired with x_k. A correlation uses the sequence held at its accepting edge, so a write during a correlation only affects later ones.
- R9: Accumulation never overflows. N equal samples of the largest magnitude (-2^(DATA_W-1) signed, 2^DATA_W-1 unsigned) give exactly plus or minus N times that magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Block can take a sample |
| in_chan_i | input | CH_W | Channel of the sample |
| in_data_i | input | DATA_W | Sample value |
| in_bs_i | input | 1 | Block-start flag of the sample |
| coef_we_i | input | 1 | Code sequence write enable |
| coef_addr_i | input | CH_W | Channel whose sequence is written |
| coef_data_i | input | NUM_TAPS | Code bits, bit 0 pairs with newest sample |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_chan_o | output | CH_W | Channel of the result |
| out_bs_o | output | 1 | Block-start flag of the result |
| out_data_o | output | ACC_W | Correlation sum, two's complement |

## Verification
The checker assumes that in_chan_i, in_data_i and in_bs_i are stable whenever in_valid_i is sampled high with in_ready_o high. It also assumes reset is the only thing that can abort a correlation. The stimulus changes inputs only on falling edges and holds a sample for exactly one accepting edge. It raises in_valid_i during a correlation only to show that the request is ignored. Two instances, one signed with OSR=2 and CELLS=3 and one unsigned with OSR=1 and CELLS=2, get the same stimulus. Their outputs are compared with sums over a behavioural history model. The stimulus includes extreme-magnitude runs and code writes made while a correlation is running.

// File: rtl/bincorr_pkg.sv
package bincorr_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} corr_state_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/bincorr_hist.sv
module bincorr_hist #(
  parameter int DATA_W   = 8,
  parameter int NUM_TAPS = 8,
  parameter int NUM_CHAN = 4,
  parameter int OSR      = 1,
  parameter int CH_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  output logic [DATA_W-1:0] taps_o [NUM_TAPS]
);
  localparam int HIST = (NUM_TAPS - 1) * OSR + 1;

  logic [DATA_W-1:0] mem_q [NUM_CHAN][HIST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CHAN; c++)
        for (int i = 0; i < HIST; i++) mem_q[c][i] <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (wr_chan_i == CH_W'(c)) begin
          mem_q[c][0] <= wr_data_i;
          for (int i = 1; i < HIST; i++) mem_q[c][i] <= mem_q[c][i-1];
        end
      end
    end
  end

  // strided tap selection: newest, then every OSR-th older sample
  always_comb begin
    for (int k = 0; k < NUM_TAPS; k++) taps_o[k] = mem_q[rd_chan_i][k*OSR];
  end
endmodule

// File: rtl/bincorr_cells.sv
module bincorr_cells #(
  parameter int DATA_W    = 8,
  parameter int NUM_TAPS  = 8,
  parameter int CELLS     = 2,
  parameter int STEPS     = 4,
  parameter int STEP_W    = 2,
  parameter int ACC_W     = 12,
  parameter bit IN_SIGNED = 1'b1
) (
  input  logic [DATA_W-1:0]       taps_i [NUM_TAPS],
  input  logic [NUM_TAPS-1:0]     coef_i,
  input  logic [STEP_W-1:0]       step_i,
  output logic signed [ACC_W-1:0] part_o
);
  localparam int PAD   = STEPS * CELLS;
  localparam int IDX_W = (PAD > 1) ? $clog2(PAD) : 1;

  logic [DATA_W-1:0]       tap_pad [PAD];
  logic [PAD-1:0]          coef_pad;
  logic [PAD-1:0]          used_pad;
  logic signed [ACC_W-1:0] term [CELLS];

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    if (i < NUM_TAPS) begin : g_real
      assign tap_pad[i]  = taps_i[i];
      assign coef_pad[i] = coef_i[i];
      assign used_pad[i] = 1'b1;
    end else begin : g_fill
      assign tap_pad[i]  = '0;
      assign coef_pad[i] = 1'b0;
      assign used_pad[i] = 1'b0;
    end
  end

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    logic [IDX_W-1:0]        idx;
    logic signed [ACC_W-1:0] ext;
    assign idx = IDX_W'(int'(step_i) * CELLS + k);
    if (IN_SIGNED) begin : g_sx
      assign ext = ACC_W'($signed(tap_pad[idx]));
    end else begin : g_zx
      assign ext = ACC_W'(tap_pad[idx]);
    end
    assign term[k] = !used_pad[idx] ? '0 : (coef_pad[idx] ? ext : -ext);
  end

  always_comb begin
    part_o = '0;
    for (int k = 0; k < CELLS; k++) part_o = part_o + term[k];
  end
endmodule

// File: rtl/bincorr_ctrl.sv
module bincorr_ctrl
  import bincorr_pkg::*;
#(
  parameter int STEPS  = 4,
  parameter int STEP_W = 2,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [CH_W-1:0]   in_chan_i,
  input  logic              in_bs_i,
  output logic              in_ready_o,
  output logic              accept_o,
  output logic              busy_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              bs_o
);
  corr_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [CH_W-1:0]   chan_q;
  logic              bs_q;

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept_o   = in_valid_i && in_ready_o;
  assign busy_o     = (state_q == ST_BUSY);
  assign last_o     = busy_o && (step_q == STEP_W'(STEPS - 1));
  assign step_o     = step_q;
  assign chan_o     = chan_q;
  assign bs_o       = bs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      chan_q  <= '0;
      bs_q    <= 1'b0;
    end else if (accept_o) begin
      state_q <= ST_BUSY;
      step_q  <= '0;
      chan_q  <= in_chan_i;
      bs_q    <= in_bs_i;
    end else if (busy_o) begin
      if (last_o) state_q <= ST_IDLE;
      else        step_q  <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/bincorr_top.sv
module bincorr_top
  import bincorr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_TAPS  = 8,
  parameter int NUM_CHAN  = 4,
  parameter int OSR       = 1,
  parameter int CELLS     = 2,
  parameter bit IN_SIGNED = 1'b1,
  localparam int CH_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int ACC_W    = DATA_W + $clog2(NUM_TAPS) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [CH_W-1:0]     in_chan_i,
  input  logic [DATA_W-1:0]   in_data_i,
  input  logic                in_bs_i,
  input  logic                coef_we_i,
  input  logic [CH_W-1:0]     coef_addr_i,
  input  logic [NUM_TAPS-1:0] coef_data_i,
  output logic                out_valid_o,
  output logic [CH_W-1:0]     out_chan_o,
  output logic                out_bs_o,
  output logic [ACC_W-1:0]    out_data_o
);
  localparam int STEPS  = ceil_div(NUM_TAPS, CELLS);
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic                    accept, busy, last, cur_bs;
  logic [STEP_W-1:0]       step;
  logic [CH_W-1:0]         cur_chan;
  logic [DATA_W-1:0]       taps [NUM_TAPS];
  logic [NUM_TAPS-1:0]     coef_mem [NUM_CHAN];
  logic [NUM_TAPS-1:0]     coef_q;
  logic signed [ACC_W-1:0] part, acc_q, acc_nxt;

  bincorr_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W), .CH_W(CH_W)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_chan_i, .in_bs_i,
    .in_ready_o, .accept_o(accept), .busy_o(busy), .last_o(last),
    .step_o(step), .chan_o(cur_chan), .bs_o(cur_bs)
  );

  bincorr_hist #(
    .DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .NUM_CHAN(NUM_CHAN), .OSR(OSR), .CH_W(CH_W)
  ) u_hist (
    .clk_i, .rst_ni, .wr_en_i(accept), .wr_chan_i(in_chan_i), .wr_data_i(in_data_i),
    .rd_chan_i(cur_chan), .taps_o(taps)
  );

  bincorr_cells #(
    .DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .CELLS(CELLS), .STEPS(STEPS),
    .STEP_W(STEP_W), .ACC_W(ACC_W), .IN_SIGNED(IN_SIGNED)
  ) u_cells (
    .taps_i(taps), .coef_i(coef_q), .step_i(step), .part_o(part)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CHAN; c++) coef_mem[c] <= '0;
    end else if (coef_we_i) begin
      coef_mem[coef_addr_i] <= coef_data_i;
    end
  end

  // sequence is frozen at acceptance so in-flight results ignore later writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     coef_q <= '0;
    else if (accept) coef_q <= coef_mem[in_chan_i];
  end

  assign acc_nxt = acc_q + part;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (accept) acc_q <= '0;
    else if (busy)   acc_q <= acc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_chan_o  <= '0;
      out_bs_o    <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= last;
      if (last) begin
        out_chan_o <= cur_chan;
        out_bs_o   <= cur_bs;
        out_data_o <= acc_nxt;
      end
    end
  end
endmodule

// File: rtl/bincorr_chk.sv
module bincorr_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_TAPS  = 8,
  parameter int CH_W      = 2,
  parameter int ACC_W     = 12,
  parameter int STEPS     = 4,
  parameter bit IN_SIGNED = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_i,
  input logic [CH_W-1:0]  in_chan_i,
  input logic             in_bs_i,
  input logic             out_valid_i,
  input logic [CH_W-1:0]  out_chan_i,
  input logic             out_bs_i,
  input logic [ACC_W-1:0] out_data_i
);
  localparam int MAXMAG = IN_SIGNED ? (2 ** (DATA_W - 1)) : (2 ** DATA_W - 1);
  localparam int LIM    = NUM_TAPS * MAXMAG;

  logic [31:0]     cyc_q;
  logic [CH_W-1:0] chan_q;
  logic            bs_q;
  logic            acc_hs;

  assign acc_hs = in_valid_i && in_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      chan_q <= '0;
      bs_q   <= 1'b0;
    end else if (acc_hs) begin
      cyc_q  <= 32'd1;
      chan_q <= in_chan_i;
      bs_q   <= in_bs_i;
    end else if (out_valid_i) begin
      cyc_q  <= '0;
    end else if (cyc_q != 0) begin
      cyc_q  <= cyc_q + 32'd1;
    end
  end

  assert_ready_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hs |=> !in_ready_i);

  assert_ready_with_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> in_ready_i);

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |=> !out_valid_i);

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (cyc_q == 32'(STEPS + 1)));

  assert_chan_echo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (out_chan_i == chan_q && out_bs_i == bs_q));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> ((int'($signed(out_data_i)) <= LIM) && (int'($signed(out_data_i)) >= -LIM)));
endmodule

bind bincorr_top bincorr_chk #(
  .DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS), .CH_W(CH_W), .ACC_W(ACC_W),
  .STEPS(STEPS), .IN_SIGNED(IN_SIGNED)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_i(in_ready_o),
  .in_chan_i(in_chan_i), .in_bs_i(in_bs_i), .out_valid_i(out_valid_o),
  .out_chan_i(out_chan_o), .out_bs_i(out_bs_o), .out_data_i(out_data_o)
);

// File: tb/bincorr_tb_top.sv
module bincorr_tb_top;
  localparam int NT = 8;
  localparam int NC = 4;
  localparam int STEPS_S = 3;  // ceil(8/3)
  localparam int STEPS_U = 4;  // ceil(8/2)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bs = 1'b0, coef_we = 1'b0;
  logic [1:0] in_chan = '0, coef_addr = '0;
  logic [7:0] in_data = '0;
  logic [NT-1:0] coef_data = '0;

  logic rdy_s, rdy_u, ov_s, ov_u, ob_s, ob_u;
  logic [1:0] oc_s, oc_u;
  logic [11:0] od_s, od_u;

  int n_chk = 0, n_err = 0;
  logic [7:0] hist [NC][16];
  logic [NT-1:0] coef_m [NC];

  always #5 clk = ~clk;

  bincorr_top #(.DATA_W(8), .NUM_TAPS(NT), .NUM_CHAN(NC), .OSR(2), .CELLS(3), .IN_SIGNED(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy_s), .in_chan_i(in_chan),
    .in_data_i(in_data), .in_bs_i(in_bs), .coef_we_i(coef_we), .coef_addr_i(coef_addr),
    .coef_data_i(coef_data), .out_valid_o(ov_s), .out_chan_o(oc_s), .out_bs_o(ob_s), .out_data_o(od_s));

  bincorr_top #(.DATA_W(8), .NUM_TAPS(NT), .NUM_CHAN(NC), .OSR(1), .CELLS(2), .IN_SIGNED(1'b0)) dut_u_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(rdy_u), .in_chan_i(in_chan),
    .in_data_i(in_data), .in_bs_i(in_bs), .coef_we_i(coef_we), .coef_addr_i(coef_addr),
    .coef_data_i(coef_data), .out_valid_o(ov_u), .out_chan_o(oc_u), .out_bs_o(ob_u), .out_data_o(od_u));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_sum(input int ch, input bit sgn, input int osr);
    int s = 0;
    for (int k = 0; k < NT; k++) begin
      int v = sgn ? int'($signed(hist[ch][k*osr])) : int'(hist[ch][k*osr]);
      s += coef_m[ch][k] ? v : -v;
    end
    return s;
  endfunction

  task automatic write_coef(input int ch, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 2'(ch); coef_data = NT'(val);
    @(negedge clk);
    coef_we = 1'b0;
    coef_m[ch] = NT'(val);
  endtask

  // garble: raise in_valid with other data while busy (R6); cwr: rewrite code mid-flight (R8)
  task automatic send(input int ch, input int d, input bit bs, input bit garble,
                      input bit cwr, input int cwr_val, input string tag);
    int exp_s, exp_u;
    bit got_s = 0, got_u = 0;
    while (!(rdy_s && rdy_u)) @(negedge clk);
    in_valid = 1'b1; in_chan = 2'(ch); in_data = 8'(d); in_bs = bs;
    for (int i = 15; i > 0; i--) hist[ch][i] = hist[ch][i-1];
    hist[ch][0] = 8'(d);
    exp_s = model_sum(ch, 1'b1, 2);
    exp_u = model_sum(ch, 1'b0, 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (k == 1) begin
        chk({tag, " R6 ready low while busy (s)"}, int'(rdy_s), 0);
        chk({tag, " R6 ready low while busy (u)"}, int'(rdy_u), 0);
        if (garble) begin
          in_valid = 1'b1; in_chan = 2'($urandom_range(0, 3)); in_data = 8'($urandom);
        end
        if (cwr) begin
          coef_we = 1'b1; coef_addr = 2'(ch); coef_data = NT'(cwr_val);
        end
      end
      if (k == 2) begin
        in_valid = 1'b0;
        if (cwr) begin
          coef_we = 1'b0;
          coef_m[ch] = NT'(cwr_val);
        end
      end
      if (ov_s && !got_s) begin
        got_s = 1;
        chk({tag, " R2 R3 R4 R8 signed sum"}, int'($signed(od_s)), exp_s);
        chk({tag, " R5 chan (s)"}, int'(oc_s), ch);
        chk({tag, " R5 bs (s)"}, int'(ob_s), int'(bs));
        chk({tag, " R7 latency (s)"}, k, STEPS_S + 1);
        chk({tag, " R6 ready back with result (s)"}, int'(rdy_s), 1);
      end
      if (ov_u && !got_u) begin
        got_u = 1;
        chk({tag, " R2 R3 R4 R8 unsigned sum"}, int'($signed(od_u)), exp_u);
        chk({tag, " R5 chan (u)"}, int'(oc_u), ch);
        chk({tag, " R5 bs (u)"}, int'(ob_u), int'(bs));
        chk({tag, " R7 latency (u)"}, k, STEPS_U + 1);
      end
      if (k == STEPS_S + 2) chk({tag, " R7 single pulse (s)"}, int'(ov_s), 0);
      @(negedge clk);
    end
    chk({tag, " R7 result seen (s)"}, int'(got_s), 1);
    chk({tag, " R7 result seen (u)"}, int'(got_u), 1);
    chk({tag, " R7 single pulse (u)"}, int'(ov_u), 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int c = 0; c < NC; c++) begin
      coef_m[c] = '0;
      for (int i = 0; i < 16; i++) hist[c][i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 ready in reset (s)", int'(rdy_s), 1);
    chk("R1 no result in reset (s)", int'(ov_s), 0);
    chk("R1 no result in reset (u)", int'(ov_u), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset (u)", int'(rdy_u), 1);
    // cleared histories and all-zero codes: only -x0 remains
    send(0, 5, 1'b1, 1'b0, 1'b0, 0, "R1");
    send(2, 8'hF0, 1'b0, 1'b0, 1'b0, 0, "R1");

    // extreme magnitudes, both code polarities (R9)
    write_coef(1, 8'hFF);
    for (int i = 0; i < 15; i++) send(1, 8'h80, 1'b0, 1'b0, 1'b0, 0, "R9 neg");
    write_coef(1, 8'h00);
    send(1, 8'h80, 1'b0, 1'b0, 1'b0, 0, "R9 pos");
    write_coef(3, 8'hFF);
    for (int i = 0; i < 15; i++) send(3, 8'hFF, 1'b0, 1'b0, 1'b0, 0, "R9 max");

    // single-bit code: isolates the pairing of bit 7 with the oldest tap (R2 R8)
    write_coef(0, 8'h80);
    for (int i = 0; i < 16; i++) send(0, i + 1, 1'b0, 1'b0, 1'b0, 0, "R2 R8 oldest");

    for (int c = 0; c < NC; c++) write_coef(c, int'($urandom_range(0, 255)));
    for (int n = 0; n < 300; n++) begin
      bit g  = ($urandom_range(0, 4) == 0);
      bit cw = ($urandom_range(0, 5) == 0);
      send(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
           g, cw, int'($urandom_range(0, 255)), "rand R4 R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule